// File: doc/BRIEF.md
# Two-Channel Register-Mapped Down-Counting Timer

This block holds two independent 24-bit down counters behind a small 32-bit read/write register bus. Software sets a reload value and a control word for each channel. The control word holds a prescale, a periodic/one-shot mode bit, an interrupt enable and a run bit. A channel counts down once every (prescale+1) clock cycles. When it runs out, it raises its bit in a shared status register. In periodic mode it then reloads and carries on. In one-shot mode it stops and drops its run bit, so software can poll for completion.

The live count of channel 1 can be read back, so that channel can serve as a free-running time base. Status bits are cleared by writing ones. One interrupt line is the OR, over both channels, of each status bit gated by that channel's enable.

Each channel is controlled by a three-state machine:
- IDLE is the state after reset and after a one-shot expiry. The channel holds no live count.
- RUN means the channel is counting.
- HALT means the channel is paused with its count kept.

The transitions are:
- START (IDLE to RUN): a control write with the run bit set. It loads the count from the reload register.
- PAUSE (RUN to HALT): a control write with the run bit clear.
- RESUME (HALT to RUN): a control write with the run bit set. It does not reload.
- FINISH (RUN to IDLE): expiry in one-shot mode.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The control register of channel n sits at byte offset 0x00+4n. Its fields are:
  - bit 30: run. It reads 1 only while the channel is in RUN.
  - bit 29: interrupt enable.
  - bit 27: periodic (1) or one-shot (0).
  - bits 7:0: prescale.
  - All other bits read zero.
- R3: The reload register of channel n sits at 0x08+4n and keeps the low 24 bits written; the upper 8 bits read zero. A START loads the count from it. Channel 1's live count reads at 0x14 in bits 23:0, with bits 31:24 zero.
- R4: In RUN the count drops by one once every (prescale+1) clock cycles. The first step comes prescale+1 cycles after the START or RESUME write.
- R5: In one-shot mode a channel started with reload N and prescale P expires N·(P+1) cycles after the START write. Its count is then 0 and its run bit reads 0.
- R6: In periodic mode, expiry reloads the count from the reload register and counting goes on, setting the status bit at every expiry.
- R7: Writing the run bit as 0 freezes the count. Writing it back to 1 resumes from the frozen value without a reload.
- R8: The status register sits at 0x18. On expiry, bit 0 is set for channel 0 and bit 1 for channel 1, whatever the interrupt enable is.
- R9: Writing the status register clears each bit written as 1 and leaves the bits written as 0 unchanged. A simultaneous expiry wins.
- R10: `irq_o` is high exactly when some channel has both its status bit and its interrupt enable set.
- R11: Writes to unmapped offsets change nothing, and reads of them return zero.
- R12: `rdata_o` is registered. It shows the addressed value in the cycle after `rd_en_i` is sampled and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The live count of channel 1 is sampled at known cycle offsets under three patterns:
- A slow prescale of 3 with a large reload shows the divide-by-(prescale+1) stepping.
- A prescale of 0 with a reload of 3 in periodic mode exposes the reload wrap every third cycle.
- A one-shot with prescale 1 and reload 5 pins the exact expiry cycle, by reading status one cycle before and at expiry.

A pause and resume in the middle of a run tells a frozen count apart from a reload. Channel 0 is expired with its interrupt masked and then unmasked. This separates the status bit from the interrupt line and checks selective write-one-to-clear.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int DATA_W  = 32;
    localparam int RUN_BIT = 30;
    localparam int IE_BIT  = 29;
    localparam int PER_BIT = 27;

    localparam logic [7:0] OFS_CTL_BASE  = 8'h00;
    localparam logic [7:0] OFS_LOAD_BASE = 8'h08;
    localparam logic [7:0] OFS_LIVE1     = 8'h14;
    localparam logic [7:0] OFS_STATUS    = 8'h18;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_HALT = 2'd2
    } ch_state_e;

    function automatic logic [7:0] ctl_ofs(input int ch);
        return OFS_CTL_BASE + 8'(4 * ch);
    endfunction

    function automatic logic [7:0] load_ofs(input int ch);
        return OFS_LOAD_BASE + 8'(4 * ch);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] phase_q;

    assign tick_o = en_i && (phase_q == psc_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!en_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // A nonzero prescale never yields two ticks in a row
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && psc_i != '0) |=> (!tick_o || psc_i == '0)); // R4

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we_i,
    input  logic             run_i,
    input  logic             ie_i,
    input  logic             per_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             run_o,
    output logic             ie_o,
    output logic             per_o,
    output logic [PSC_W-1:0] psc_o,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [PSC_W-1:0] psc_q;
    logic             ie_q;
    logic             per_q;
    logic             tick;
    logic             last_step;
    logic             start_load;

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state_q == CH_RUN),
        .psc_i  (psc_q),
        .tick_o (tick)
    );

    assign last_step  = (count_q[CNT_W-1:1] == '0);
    assign expire_o   = (state_q == CH_RUN) && tick && last_step;
    assign start_load = (state_q == CH_IDLE) && ctl_we_i && run_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: START, PAUSE, RESUME, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (ctl_we_i && run_i) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (expire_o && !per_q)        state_d = CH_IDLE;
                else if (ctl_we_i && !run_i)   state_d = CH_HALT;
            end
            CH_HALT: begin
                if (ctl_we_i && run_i) state_d = CH_RUN;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Datapath and field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            psc_q   <= '0;
            ie_q    <= 1'b0;
            per_q   <= 1'b0;
        end else begin
            if (ctl_we_i) begin
                psc_q <= psc_i;
                ie_q  <= ie_i;
                per_q <= per_i;
            end
            if (start_load) begin
                count_q <= reload_i;
            end else if (state_q == CH_RUN && tick) begin
                if (last_step) begin
                    count_q <= per_q ? reload_i : '0;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
        end
    end

    assign run_o   = (state_q == CH_RUN);
    assign ie_o    = ie_q;
    assign per_o   = per_q;
    assign psc_o   = psc_q;
    assign count_o = count_q;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && ctl_we_i && run_i) |=> (count_q == $past(reload_i))); // R3

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !per_q) |=> (!run_o && count_q == '0)); // R5

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && per_q) |=> (count_q == $past(reload_i))); // R6

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !(ctl_we_i && run_i)) |=> $stable(count_q)); // R7

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 24,
    parameter int PSC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);

    localparam int NCH = 2;

    logic [NCH-1:0]   run_v, ie_v, per_v, expire_v;
    logic [CNT_W-1:0] count_a [NCH];
    logic [DATA_W-1:0] ctl_rd_a [NCH];
    logic [DATA_W-1:0] load_rd_a [NCH];
    logic [NCH-1:0]   status_q;
    logic             status_we;
    logic [DATA_W-1:0] rd_mux;
    logic             rd_mapped;
    logic             unused_wdata;

    assign unused_wdata = ^{wdata_i[31], wdata_i[28], wdata_i[26:CNT_W]};

    function automatic logic addr_is(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic             ctl_we;
        logic             load_we;
        logic [CNT_W-1:0] reload_q;
        logic [PSC_W-1:0] psc_w;

        assign ctl_we  = wr_en_i && addr_is(addr_i, ctl_ofs(ch));
        assign load_we = wr_en_i && addr_is(addr_i, load_ofs(ch));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_q <= '0;
            end else if (load_we) begin
                reload_q <= wdata_i[CNT_W-1:0];
            end
        end

        tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we_i (ctl_we),
            .run_i    (wdata_i[RUN_BIT]),
            .ie_i     (wdata_i[IE_BIT]),
            .per_i    (wdata_i[PER_BIT]),
            .psc_i    (wdata_i[PSC_W-1:0]),
            .reload_i (reload_q),
            .run_o    (run_v[ch]),
            .ie_o     (ie_v[ch]),
            .per_o    (per_v[ch]),
            .psc_o    (psc_w),
            .count_o  (count_a[ch]),
            .expire_o (expire_v[ch])
        );

        always_comb begin
            ctl_rd_a[ch]          = '0;
            ctl_rd_a[ch][RUN_BIT] = run_v[ch];
            ctl_rd_a[ch][IE_BIT]  = ie_v[ch];
            ctl_rd_a[ch][PER_BIT] = per_v[ch];
            ctl_rd_a[ch][PSC_W-1:0] = psc_w;
        end

        assign load_rd_a[ch] = DATA_W'(reload_q);

        AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            expire_v[ch] |=> status_q[ch]); // R8

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (status_we && wdata_i[ch] && !expire_v[ch]) |=> !status_q[ch]); // R9
    end

    assign status_we = wr_en_i && addr_is(addr_i, OFS_STATUS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~(status_we ? wdata_i[NCH-1:0] : '0)) | expire_v;
        end
    end

    assign irq_o = |(status_q & ie_v);

    always_comb begin
        rd_mux    = '0;
        rd_mapped = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr_is(addr_i, ctl_ofs(ch))) begin
                rd_mux    = ctl_rd_a[ch];
                rd_mapped = 1'b1;
            end
            if (addr_is(addr_i, load_ofs(ch))) begin
                rd_mux    = load_rd_a[ch];
                rd_mapped = 1'b1;
            end
        end
        if (addr_is(addr_i, OFS_LIVE1)) begin
            rd_mux    = DATA_W'(count_a[1]);
            rd_mapped = 1'b1;
        end
        if (addr_is(addr_i, OFS_STATUS)) begin
            rd_mux    = DATA_W'(status_q);
            rd_mapped = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_mux;
        end
    end

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(expire_v & ie_v)) && !wr_en_i) |=> irq_o); // R10

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_mapped) |=> (rdata_o == '0)); // R11

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)); // R12

endmodule

// File: tb/dual_down_timer_test.sv
`timescale 1ns/1ps
module dual_down_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_edge = 0;
    logic rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dual_down_timer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_pend <= rst_n && rd_en;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: one cycle after a sampled read, compare with the queue head
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R12: read data 0x%08h with no expected entry", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        last_edge = cyc;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] model(input int init, input int p, input int j, input bit periodic);
        int t;
        t = j / (p + 1);
        if (periodic) return 32'(init - (t % init));
        return (t >= init) ? 32'd0 : 32'(init - t);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        int c0, held, c1;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        rd(8'h00, 0, "R1 ctl0");
        rd(8'h04, 0, "R1 ctl1");
        rd(8'h08, 0, "R1 load0");
        rd(8'h0C, 0, "R1 load1");
        rd(8'h14, 0, "R1 live1");
        rd(8'h18, 0, "R1 status");

        // R2 / R3 field readback, channel 0 kept out of RUN
        wr(8'h08, 32'hABCDEF12);
        rd(8'h08, 32'h00CDEF12, "R3 load0 24 bits");
        wr(8'h00, 32'hBFFFFFFF);
        rd(8'h00, 32'h280000FF, "R2 ctl0 fields");
        wr(8'h00, 32'h0);

        // R3 / R4 start channel 1 with prescale 3
        wr(8'h0C, 32'd100);
        wr(8'h04, 32'h40000003);
        c0 = last_edge;
        rd(8'h04, 32'h40000003, "R2 ctl1 run bit");
        for (int k = 0; k < 6; k++) rd(8'h14, model(100, 3, cyc - c0, 0), "R4 live1 step");
        idle(7);
        rd(8'h14, model(100, 3, cyc - c0, 0), "R3 live1 after start");

        // R7 pause and resume
        while (cyc - c0 < 30) @(negedge clk);
        wr(8'h04, 32'h00000003);
        held = model(100, 3, last_edge - c0, 0);
        rd(8'h14, 32'(held), "R7 frozen count");
        idle(10);
        rd(8'h14, 32'(held), "R7 still frozen");
        wr(8'h04, 32'h40000003);
        c1 = last_edge;
        idle(9);
        rd(8'h14, model(held, 3, cyc - c1, 0), "R7 resumed without reload");

        // R5 let the running one-shot drain, then time a fresh one precisely
        wr(8'h0C, 32'd5);
        wr(8'h04, 32'h40000001);
        idle(500);
        rd(8'h04, 32'h00000001, "R5 run bit cleared");
        rd(8'h14, 0, "R5 count at zero");
        rd(8'h18, 32'h2, "R8 status bit 1");
        wr(8'h18, 32'h1F);
        rd(8'h18, 0, "R9 clear all");
        wr(8'h04, 32'h40000001);
        c0 = last_edge;
        while (cyc - c0 < 9) @(negedge clk);
        rd(8'h18, 0, "R5 not yet expired");
        rd(8'h18, 32'h2, "R5 expired on time");
        rd(8'h14, 0, "R5 count zero");
        rd(8'h04, 32'h00000001, "R5 run bit dropped");
        check("R10 irq masked", {31'b0, irq}, 32'd0);

        // R6 periodic wrap
        wr(8'h18, 32'h2);
        wr(8'h0C, 32'd3);
        wr(8'h04, 32'h48000000);
        c0 = last_edge;
        for (int k = 0; k < 6; k++) rd(8'h14, model(3, 0, cyc - c0, 1), "R6 periodic count");
        rd(8'h18, 32'h2, "R6 status set");
        wr(8'h04, 32'h08000000);
        wr(8'h18, 32'h1F);

        // R8 / R9 / R10 channel 0 one-shot with interrupt masked, then unmasked
        wr(8'h08, 32'd4);
        wr(8'h00, 32'h40000000);
        idle(10);
        rd(8'h18, 32'h1, "R8 status bit 0 with ie off");
        check("R10 irq low while masked", {31'b0, irq}, 32'd0);
        wr(8'h00, 32'h20000000);
        check("R10 irq high when enabled", {31'b0, irq}, 32'd1);
        wr(8'h18, 32'h2);
        rd(8'h18, 32'h1, "R9 zero bits leave status");
        check("R9 irq still high", {31'b0, irq}, 32'd1);
        wr(8'h18, 32'h1);
        rd(8'h18, 0, "R9 bit 0 cleared");
        check("R10 irq low after clear", {31'b0, irq}, 32'd0);

        // R11 unmapped offsets
        wr(8'h10, 32'hFFFFFFFF);
        wr(8'h1C, 32'hFFFFFFFF);
        rd(8'h10, 0, "R11 read 0x10");
        rd(8'h1C, 0, "R11 read 0x1C");
        rd(8'h00, 32'h20000000, "R11 ctl0 untouched");

        // R12 registered read timing and hold
        rd_en = 1'b1; addr = 8'h08;
        exp_q.push_back(32'd4); tag_q.push_back("R12 load0 after edge");
        check("R12 old data before edge", rdata, 32'h20000000);
        @(negedge clk);
        rd_en = 1'b0;
        addr = 8'h18;
        idle(3);
        check("R12 data holds", rdata, 32'd4);

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule